// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block translates a virtual page number, combined with an address-space tag, into a physical frame number within one combinational cycle. It holds a set of entries, all searched at once. A non-global entry matches only when the presented address-space tag is equal to its own. An entry with its global bit set matches under any tag. The low page-offset bits go straight from the virtual address to the physical address. Each lookup also reports the matching entry's attribute bits and signals two exception conditions: a missing translation, and a store to a page that has not been modified.

Software fills the buffer after every miss. A fill writes a tag half (page number and address-space tag) and a frame half (frame number, uncached, dirty, valid and global bits). The slot is either named explicitly or taken from a free-running replacement counter. That counter never selects the lowest group of slots, so those slots can hold permanent mappings. A probe port searches for a tag and returns the index of the matching slot, or a fail flag.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `lk_paddr` is the entry's 20-bit frame number followed by the 12 untranslated offset bits of `lk_vaddr`, in the same cycle the inputs are presented.
- R2: A non-global entry (global bit = 0) matches only when `lk_asid` equals its stored tag. An entry with global bit = 1 matches under any `lk_asid`.
- R3: When no entry matches, `lk_hit` = 0 and `lk_miss` = 1, and the frame field of `lk_paddr` is zero.
- R4: A hit on an entry whose valid bit is 0 raises `lk_inval`, and `lk_mod` stays 0.
- R5: A store (`lk_store` = 1) that hits a valid entry with dirty bit 0 raises `lk_mod`. A load, or a store to a dirty entry, raises no exception.
- R6: An indexed write replaces the slot `wr_idx` at the next rising clock edge. The old mapping in that slot then no longer matches.
- R7: After reset, `rnd_idx` = ENTRIES-1. It decrements by one every cycle. In the cycle after it reaches SAFE (8), it returns to ENTRIES-1, so it never points below SAFE.
- R8: A random write fills the slot shown on `rnd_idx` in the cycle before the edge. When `wr_idx_en` and `wr_rnd_en` are both high, the indexed write takes precedence.
- R9: The probe port returns the index of the entry that matches `pr_vpn`/`pr_asid` under the rule of R2, with `pr_fail` = 0. With no match, it returns `pr_fail` = 1 and `pr_idx` = 0.
- R10: After reset, no slot matches any lookup or probe until it is written.
- R11: `lk_nc`, `lk_dirty` and `lk_valid` copy the matching entry's uncached, dirty and valid bits. On a miss they are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Current address-space tag |
| lk_store | input | 1 | Access is a store |
| lk_hit | output | 1 | A matching entry exists |
| lk_miss | output | 1 | No matching entry (refill exception) |
| lk_paddr | output | 32 | Translated physical address |
| lk_nc | output | 1 | Matching entry is uncached |
| lk_dirty | output | 1 | Matching entry's dirty bit |
| lk_valid | output | 1 | Matching entry's valid bit |
| lk_inval | output | 1 | Invalid-translation exception |
| lk_mod | output | 1 | Modify exception |
| wr_idx_en | input | 1 | Write to the slot given by wr_idx |
| wr_rnd_en | input | 1 | Write to the slot given by rnd_idx |
| wr_idx | input | 6 | Explicit slot for an indexed write |
| wr_vpn | input | 20 | Tag half: virtual page number |
| wr_asid | input | 6 | Tag half: address-space tag |
| wr_pfn | input | 20 | Frame half: physical frame number |
| wr_nc | input | 1 | Frame half: uncached |
| wr_dirty | input | 1 | Frame half: dirty (writable) |
| wr_valid | input | 1 | Frame half: valid |
| wr_glob | input | 1 | Frame half: global |
| rnd_idx | output | 6 | Current replacement index |
| pr_vpn | input | 20 | Probe page number |
| pr_asid | input | 6 | Probe address-space tag |
| pr_idx | output | 6 | Index of the probed match |
| pr_fail | output | 1 | Probe found no match |

## Verification
The bench builds the block with its defaults: 64 slots, 8 protected slots, 20-bit page and frame numbers and a 6-bit tag. With these values the replacement counter needs 56 cycles to run its full cycle, so the bench watches it wrap from 8 to 63 more than once. The bench places its long-lived mappings only in the protected slots 0 to 7. Random fills therefore can never overwrite them, and no two slots ever share a tag.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 20;
    localparam int ASID_W = 6;
    localparam int OFF_W  = 12;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PFN_W + OFF_W;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
    } tag_t;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             nc;
        logic             dirty;
        logic             valid;
        logic             glob;
    } frame_t;

    function automatic logic tag_hit(tag_t stored, logic glob, tag_t key);
        return (stored.vpn == key.vpn) && (glob || (stored.asid == key.asid));
    endfunction
endpackage

// File: rtl/tlb_random.sv
module tlb_random #(
    parameter int ENTRIES = 64,
    parameter int SAFE    = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] LOW = IDX_W'(SAFE);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= TOP;
        else if (idx == LOW)
            idx <= TOP;
        else
            idx <= idx - 1'b1;
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  tag_t   [ENTRIES-1:0] tags,
    input  frame_t [ENTRIES-1:0] frames,
    input  logic   [ENTRIES-1:0] loaded,
    input  tag_t                 key,
    output logic   [ENTRIES-1:0] match
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = loaded[i] && tag_hit(tags[i], frames[i].glob, key);
    end
endmodule

// File: rtl/tlb_enc.sv
module tlb_enc #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     sel,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) idx = idx | IDX_W'(i);
        end
        any = |sel;
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int SAFE    = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_paddr,
    output logic              lk_nc,
    output logic              lk_dirty,
    output logic              lk_valid,
    output logic              lk_inval,
    output logic              lk_mod,
    input  logic              wr_idx_en,
    input  logic              wr_rnd_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_nc,
    input  logic              wr_dirty,
    input  logic              wr_valid,
    input  logic              wr_glob,
    output logic [IDX_W-1:0]  rnd_idx,
    input  logic [VPN_W-1:0]  pr_vpn,
    input  logic [ASID_W-1:0] pr_asid,
    output logic [IDX_W-1:0]  pr_idx,
    output logic              pr_fail
);
    tag_t   [ENTRIES-1:0] tags;
    frame_t [ENTRIES-1:0] frames;
    logic   [ENTRIES-1:0] loaded;

    tag_t   lk_key, pr_key, wr_tag;
    frame_t wr_frame, sel_frame;
    logic   [ENTRIES-1:0] lk_match, pr_match;
    logic   [IDX_W-1:0]   lk_idx;
    logic   [IDX_W-1:0]   pr_enc;
    logic                 pr_any;
    logic                 do_wr;
    logic   [IDX_W-1:0]   wr_slot;

    tlb_random #(.ENTRIES(ENTRIES), .SAFE(SAFE)) u_rnd (
        .clk(clk), .rst(rst), .idx(rnd_idx)
    );

    assign wr_tag   = '{vpn: wr_vpn, asid: wr_asid};
    assign wr_frame = '{pfn: wr_pfn, nc: wr_nc, dirty: wr_dirty,
                        valid: wr_valid, glob: wr_glob};
    assign do_wr    = wr_idx_en || wr_rnd_en;
    assign wr_slot  = wr_idx_en ? wr_idx : rnd_idx;

    always_ff @(posedge clk) begin
        if (rst)
            loaded <= '0;
        else if (do_wr)
            loaded[wr_slot] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            tags[wr_slot]   <= wr_tag;
            frames[wr_slot] <= wr_frame;
        end
    end

    assign lk_key = '{vpn: lk_vaddr[VA_W-1:OFF_W], asid: lk_asid};
    assign pr_key = '{vpn: pr_vpn, asid: pr_asid};

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam_lk (
        .tags(tags), .frames(frames), .loaded(loaded),
        .key(lk_key), .match(lk_match)
    );

    tlb_cam #(.ENTRIES(ENTRIES)) u_cam_pr (
        .tags(tags), .frames(frames), .loaded(loaded),
        .key(pr_key), .match(pr_match)
    );

    tlb_enc #(.N(ENTRIES)) u_enc_lk (.sel(lk_match), .idx(lk_idx), .any(lk_hit));
    tlb_enc #(.N(ENTRIES)) u_enc_pr (.sel(pr_match), .idx(pr_enc), .any(pr_any));

    assign sel_frame = frames[lk_idx];

    always_comb begin
        lk_miss  = !lk_hit;
        lk_paddr = {(lk_hit ? sel_frame.pfn : {PFN_W{1'b0}}), lk_vaddr[OFF_W-1:0]};
        lk_nc    = lk_hit && sel_frame.nc;
        lk_dirty = lk_hit && sel_frame.dirty;
        lk_valid = lk_hit && sel_frame.valid;
        lk_inval = lk_hit && !sel_frame.valid;
        lk_mod   = lk_hit && sel_frame.valid && lk_store && !sel_frame.dirty;
        pr_fail  = !pr_any;
        pr_idx   = pr_any ? pr_enc : '0;
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int ENTRIES = 64,
    parameter int SAFE    = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] rnd_idx,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_inval,
    input logic             lk_mod,
    input logic             lk_store,
    input logic [IDX_W-1:0] pr_idx,
    input logic             pr_fail
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] LOW = IDX_W'(SAFE);

    a_r7_rnd_floor: assert property (@(posedge clk) disable iff (rst)
        rnd_idx >= LOW);

    a_r7_rnd_step: assert property (@(posedge clk) disable iff (rst)
        (rnd_idx != LOW) |=> (rnd_idx == $past(rnd_idx) - 1'b1));

    a_r7_rnd_wrap: assert property (@(posedge clk) disable iff (rst)
        (rnd_idx == LOW) |=> (rnd_idx == TOP));

    a_r4_inval_needs_hit: assert property (@(posedge clk) disable iff (rst)
        lk_inval |-> (lk_hit && !lk_mod));

    a_r5_mod_on_store: assert property (@(posedge clk) disable iff (rst)
        lk_mod |-> (lk_store && lk_hit));

    a_r3_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        lk_miss |-> (!lk_inval && !lk_mod));

    a_r9_fail_zero: assert property (@(posedge clk) disable iff (rst)
        pr_fail |-> (pr_idx == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES), .SAFE(SAFE)) u_chk (
    .clk(clk), .rst(rst), .rnd_idx(rnd_idx), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_inval(lk_inval), .lk_mod(lk_mod),
    .lk_store(lk_store), .pr_idx(pr_idx), .pr_fail(pr_fail)
);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] lk_vaddr;
    logic [5:0]  lk_asid;
    logic        lk_store;
    logic        lk_hit, lk_miss, lk_nc, lk_dirty, lk_valid, lk_inval, lk_mod;
    logic [31:0] lk_paddr;
    logic        wr_idx_en, wr_rnd_en;
    logic [5:0]  wr_idx;
    logic [19:0] wr_vpn;
    logic [5:0]  wr_asid;
    logic [19:0] wr_pfn;
    logic        wr_nc, wr_dirty, wr_valid, wr_glob;
    logic [5:0]  rnd_idx;
    logic [19:0] pr_vpn;
    logic [5:0]  pr_asid;
    logic [5:0]  pr_idx;
    logic        pr_fail;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] m_rnd;

    always #10 clk = ~clk;

    tlb_xlate u0 (.*);

    // replacement counter model, from R7
    always @(posedge clk) begin
        if (rst) m_rnd <= 6'd63;
        else     m_rnd <= (m_rnd == 6'd8) ? 6'd63 : m_rnd - 6'd1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_wr(input logic [19:0] vpn, input logic [5:0] asid, input logic [19:0] pfn,
                          input logic nc, input logic d, input logic v, input logic g);
        wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_nc = nc; wr_dirty = d; wr_valid = v; wr_glob = g;
    endtask

    task automatic write_idx(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                             input logic [19:0] pfn, input logic nc, input logic d,
                             input logic v, input logic g);
        @(negedge clk);
        set_wr(vpn, asid, pfn, nc, d, v, g);
        wr_idx = idx; wr_idx_en = 1'b1;
        @(negedge clk);
        wr_idx_en = 1'b0;
    endtask

    task automatic write_rnd(input logic [19:0] vpn, input logic [19:0] pfn, output logic [5:0] victim);
        @(negedge clk);
        set_wr(vpn, 6'd1, pfn, 1'b0, 1'b1, 1'b1, 1'b0);
        victim = m_rnd;
        chk(rnd_idx == m_rnd, "R7 rnd before write", rnd_idx, m_rnd);
        wr_rnd_en = 1'b1;
        @(negedge clk);
        wr_rnd_en = 1'b0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic [5:0] asid, input logic st, input logic [11:0] off);
        lk_vaddr = {vpn, off}; lk_asid = asid; lk_store = st;
        #2;
    endtask

    task automatic probe(input logic [19:0] vpn, input logic [5:0] asid);
        pr_vpn = vpn; pr_asid = asid;
        #2;
    endtask

    task automatic t_reset;
        look(20'h00000, 6'd0, 1'b0, 12'h000);
        chk(!lk_hit && lk_miss, "R10 reset lookup misses", lk_hit, 0);
        chk(lk_paddr == 32'h0000_0000, "R3 miss frame zero", lk_paddr, 0);
        chk({lk_nc, lk_dirty, lk_valid} == 3'b000, "R11 attrs zero on miss", {lk_nc, lk_dirty, lk_valid}, 0);
        probe(20'h00000, 6'd0);
        chk(pr_fail && pr_idx == 6'd0, "R10 reset probe fails", {pr_fail, pr_idx}, 7'h40);
        chk(rnd_idx == 6'd63, "R7 reset rnd", rnd_idx, 63);
    endtask

    task automatic t_basic;
        write_idx(6'd2, 20'h12345, 6'd5, 20'hABCDE, 1'b1, 1'b1, 1'b1, 1'b0);
        look(20'h12345, 6'd5, 1'b0, 12'h3C4);
        chk(lk_hit && lk_paddr == 32'hABCDE3C4, "R1 hit translation", lk_paddr, 32'hABCDE3C4);
        chk({lk_nc, lk_dirty, lk_valid} == 3'b111, "R11 attrs on hit", {lk_nc, lk_dirty, lk_valid}, 3'b111);
        look(20'h12345, 6'd5, 1'b0, 12'hFFF);
        chk(lk_paddr == 32'hABCDEFFF, "R1 offset passes", lk_paddr, 32'hABCDEFFF);
        look(20'h12345, 6'd6, 1'b0, 12'h3C4);
        chk(!lk_hit && lk_miss && lk_paddr == 32'h000003C4, "R2 asid mismatch misses", lk_paddr, 32'h3C4);
    endtask

    task automatic t_global;
        write_idx(6'd3, 20'h00777, 6'd1, 20'h00042, 1'b0, 1'b1, 1'b1, 1'b1);
        look(20'h00777, 6'd33, 1'b0, 12'h010);
        chk(lk_hit && lk_paddr == 32'h00042010, "R2 global ignores asid", lk_paddr, 32'h00042010);
        chk({lk_nc, lk_dirty, lk_valid} == 3'b011, "R11 global attrs", {lk_nc, lk_dirty, lk_valid}, 3'b011);
    endtask

    task automatic t_inval;
        write_idx(6'd4, 20'h55555, 6'd5, 20'h00011, 1'b0, 1'b0, 1'b0, 1'b0);
        look(20'h55555, 6'd5, 1'b0, 12'h0);
        chk(lk_hit && lk_inval && !lk_mod, "R4 invalid exception", {lk_hit, lk_inval, lk_mod}, 3'b110);
        look(20'h55555, 6'd5, 1'b1, 12'h0);
        chk(lk_inval && !lk_mod, "R4 invalid store no modify", {lk_inval, lk_mod}, 2'b10);
    endtask

    task automatic t_modify;
        write_idx(6'd5, 20'h66666, 6'd5, 20'h00022, 1'b0, 1'b0, 1'b1, 1'b0);
        write_idx(6'd6, 20'h66667, 6'd5, 20'h00023, 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h66666, 6'd5, 1'b0, 12'h0);
        chk(lk_hit && !lk_mod && !lk_inval, "R5 load clean no exc", {lk_mod, lk_inval}, 0);
        look(20'h66666, 6'd5, 1'b1, 12'h0);
        chk(lk_mod && !lk_inval, "R5 store clean modify", {lk_mod, lk_inval}, 2'b10);
        look(20'h66667, 6'd5, 1'b1, 12'h0);
        chk(lk_hit && !lk_mod, "R5 store dirty no exc", lk_mod, 0);
    endtask

    task automatic t_overwrite;
        write_idx(6'd2, 20'h22222, 6'd5, 20'h0BEEF, 1'b0, 1'b1, 1'b1, 1'b0);
        look(20'h12345, 6'd5, 1'b0, 12'h0);
        chk(lk_miss, "R6 old mapping gone", lk_hit, 0);
        look(20'h22222, 6'd5, 1'b0, 12'h123);
        chk(lk_hit && lk_paddr == 32'h0BEEF123, "R6 new mapping", lk_paddr, 32'h0BEEF123);
    endtask

    task automatic t_probe;
        probe(20'h22222, 6'd5);
        chk(!pr_fail && pr_idx == 6'd2, "R9 probe index", pr_idx, 2);
        probe(20'h00777, 6'd9);
        chk(!pr_fail && pr_idx == 6'd3, "R9 probe global", pr_idx, 3);
        probe(20'h22222, 6'd7);
        chk(pr_fail && pr_idx == 6'd0, "R9 probe asid miss", {pr_fail, pr_idx}, 7'h40);
        probe(20'h99999, 6'd5);
        chk(pr_fail && pr_idx == 6'd0, "R9 probe fail", {pr_fail, pr_idx}, 7'h40);
    endtask

    task automatic t_random;
        logic [5:0] v;
        for (int k = 0; k < 3; k++) begin
            write_rnd(20'h30000 + 20'(k), 20'h01000 + 20'(k), v);
            chk(v >= 6'd8, "R7 victim above safe", v, 8);
            probe(20'h30000 + 20'(k), 6'd1);
            chk(!pr_fail && pr_idx == v, "R8 random slot", pr_idx, v);
            look(20'h30000 + 20'(k), 6'd1, 1'b0, 12'h0);
            chk(lk_paddr == {20'h01000 + 20'(k), 12'h0}, "R8 random data", lk_paddr, {20'h01000 + 20'(k), 12'h0});
        end
        @(negedge clk);
        set_wr(20'h40000, 6'd1, 20'h02000, 1'b0, 1'b1, 1'b1, 1'b0);
        wr_idx = 6'd7; wr_idx_en = 1'b1; wr_rnd_en = 1'b1;
        @(negedge clk);
        wr_idx_en = 1'b0; wr_rnd_en = 1'b0;
        probe(20'h40000, 6'd1);
        chk(!pr_fail && pr_idx == 6'd7, "R8 index wins", pr_idx, 7);
    endtask

    task automatic t_rnd_seq;
        bit seen_wrap = 0;
        for (int c = 0; c < 130; c++) begin
            @(negedge clk);
            #1;
            if (rnd_idx == 6'd8) begin
                @(negedge clk);
                #1;
                chk(rnd_idx == 6'd63, "R7 wrap to top", rnd_idx, 63);
                seen_wrap = 1;
            end else begin
                if (rnd_idx != m_rnd || rnd_idx < 6'd8)
                    chk(0, "R7 rnd sequence", rnd_idx, m_rnd);
            end
        end
        chk(seen_wrap, "R7 wrap observed", seen_wrap, 1);
    endtask

    initial begin
        #(20 * 100000);
        chk(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        wr_idx_en = 1'b0; wr_rnd_en = 1'b0; wr_idx = '0;
        set_wr('0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        lk_vaddr = '0; lk_asid = '0; lk_store = 1'b0;
        pr_vpn = '0; pr_asid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset;
        t_basic;
        t_global;
        t_inval;
        t_modify;
        t_overwrite;
        t_probe;
        t_random;
        t_rnd_seq;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule